// File: doc/BRIEF.md
# Key-Protected Device Configuration Register Block

This block is a small memory-mapped bank of chip configuration registers on a plain 32-bit register bus. The bus has a byte address, a write strobe, write data and combinational read data. Every write into the bank is refused until software has passed a two-step unlock. The first key must go into one kick register, and then the second key into a second kick register. The main device-control word is guarded twice: it also needs a separate lock register to hold its own key.

The bank holds per-device enable fields and drives one enable output for each device. Twelve devices use 2-bit fields that enable on the value 1. A thirteenth device uses a 2-bit field at the top of the same word and enables only on the value 3. Two further devices have 1-bit enables that, once set, cannot be cleared by software. A privilege word with a non-zero reset value sits in the bank, and so does a small field that can be written only once after reset. A sticky error output records that some write was refused.

Top module: `cfg_keyed_regs`

## Requirements
- R1: After reset, the control word at 0x40008 reads 0, the sticky word at 0x4002C reads 0, the write-once word at 0x40030 reads 0, the privilege word at 0x41C reads 0xAAAAAAAA, every dev_en bit is 0 and blocked_err is 0.
- R2: The bank is open only after 0x83E70B13 is written to 0x38 and then 0x95A4F1E0 is written to 0x3C. Before that, writes to the protected words (0x40004, 0x40008, 0x4002C, 0x40030, 0x41C) are discarded.
- R3: The bank returns to locked on any wrong value written to either kick register, and on the second key written while still locked. Once open, any value other than 0x83E70B13 written to 0x38 relocks the bank.
- R4: A write to 0x40008 takes effect only while the bank is open and the lock word at 0x40004 holds 0x0F0A0B00.
- R5: The kick registers (0x38, 0x3C) and the lock word (0x40004) always read 0.
- R6: dev_en[i] for i = 0..11 is 1 exactly when bits [2i+1:2i] of 0x40008 equal 1. dev_en[12] is 1 exactly when bits [31:30] equal 3.
- R7: Bits 0 and 1 of 0x4002C drive dev_en[13] and dev_en[14]. An accepted write can set them but never clears them, and all other bits of that word read 0.
- R8: While the bank is open, the privilege word at 0x41C takes all 32 bits of a write.
- R9: The 8-bit field at 0x40030 (bits 7:0) stores the first accepted write after reset. Later writes leave it unchanged until reset.
- R10: blocked_err becomes 1 after any discarded write to a protected word, including a second write to 0x40030. It stays 1 until reset.
- R11: Reads return the current stored value whatever the lock state. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 19 | Byte address of the access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| dev_en | output | 15 | One enable per device id |
| blocked_err | output | 1 | Sticky flag for a refused write |

## Verification
The sticky enable merge and a new enable can fall in the same write. A single write to 0x4002C carries a 0 in an already-set bit and a 1 in a clear bit. The bench then expects the readback and dev_en[14:13] to show both bits set: the refused clear and the accepted set land in one cycle. Two other coincidences are also provoked. A refused write to the write-once field is checked to leave the stored value unchanged while it raises blocked_err. A relocking kick write is followed at once by a protected write that must be discarded.

// File: rtl/cfg_keyed_pkg.sv
package cfg_keyed_pkg;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } kick_state_e;

  // Next state of the unlock sequencer for one bus cycle.
  function automatic kick_state_e kick_step(kick_state_e cur,
                                            logic hit_first, logic hit_second,
                                            logic good_first, logic good_second);
    kick_state_e nxt;
    nxt = cur;
    if (hit_first) begin
      if (!good_first)          nxt = KS_LOCKED;
      else if (cur == KS_OPEN)  nxt = KS_OPEN;
      else                      nxt = KS_HALF;
    end else if (hit_second) begin
      if (good_second && cur != KS_LOCKED) nxt = KS_OPEN;
      else                                 nxt = KS_LOCKED;
    end
    return nxt;
  endfunction

  // Two-bit device field number idx of a control word.
  function automatic logic [1:0] wide_field(logic [31:0] word, int unsigned idx);
    return word[2*idx +: 2];
  endfunction

endpackage

// File: rtl/kick_seq.sv
module kick_seq
  import cfg_keyed_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [31:0] KEY_FIRST  = 32'h83E7_0B13,
  parameter logic [31:0] KEY_SECOND = 32'h95A4_F1E0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_first,
  input  logic              wr_second,
  input  logic [DATA_W-1:0] wdata,
  output logic              open_o
);

  kick_state_e state_q, state_d;
  logic good_first, good_second;

  assign good_first  = (wdata == KEY_FIRST[DATA_W-1:0]);
  assign good_second = (wdata == KEY_SECOND[DATA_W-1:0]);

  always_comb state_d = kick_step(state_q, wr_first, wr_second, good_first, good_second);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_d;
  end

  assign open_o = (state_q == KS_OPEN);

  // R2: the bank only opens on a correct second key
  assert_open_needs_second_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_o) |-> $past(wr_second && wdata == KEY_SECOND[DATA_W-1:0]));

  // R3: any bad kick value leaves the bank locked
  assert_bad_kick_relocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_first && wdata != KEY_FIRST[DATA_W-1:0]) ||
     (wr_second && wdata != KEY_SECOND[DATA_W-1:0])) |=> !open_o);

endmodule

// File: rtl/dev_ctl_bank.sv
module dev_ctl_bank
  import cfg_keyed_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_WIDE   = 12,
  parameter int unsigned N_STICKY = 2,
  parameter logic [1:0]  WIDE_EN  = 2'd1,
  parameter logic [1:0]  TOP_EN   = 2'd3,
  localparam int unsigned NDEV    = N_WIDE + 1 + N_STICKY
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we,
  input  logic                sticky_we,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   ctl_q,
  output logic [N_STICKY-1:0] sticky_q,
  output logic [NDEV-1:0]     dev_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= wdata;
  end

  // Sticky enables: a write may only add set bits.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sticky_q <= '0;
    else if (sticky_we) sticky_q <= sticky_q | wdata[N_STICKY-1:0];
  end

  for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
    assign dev_en[i] = (wide_field(32'(ctl_q), i) == WIDE_EN);
  end

  assign dev_en[N_WIDE] = (ctl_q[DATA_W-1 -: 2] == TOP_EN);

  for (genvar j = 0; j < N_STICKY; j++) begin : g_sticky
    assign dev_en[N_WIDE+1+j] = sticky_q[j];
  end

  // R4: the control word changes only on a granted write
  assert_ctl_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q != $past(ctl_q)) |-> $past(ctl_we));

  // R7: sticky enables never fall
  assert_sticky_no_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

endmodule

// File: rtl/cfg_keyed_regs.sv
module cfg_keyed_regs
  import cfg_keyed_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned N_WIDE    = 12,
  parameter int unsigned N_STICKY  = 2,
  parameter int unsigned ONCE_W    = 8,
  parameter logic [31:0] OFF_KICK0 = 32'h0000_0038,
  parameter logic [31:0] OFF_KICK1 = 32'h0000_003C,
  parameter logic [31:0] OFF_PRIV  = 32'h0000_041C,
  parameter logic [31:0] OFF_LOCK  = 32'h0004_0004,
  parameter logic [31:0] OFF_CTL   = 32'h0004_0008,
  parameter logic [31:0] OFF_STKY  = 32'h0004_002C,
  parameter logic [31:0] OFF_ONCE  = 32'h0004_0030,
  parameter logic [31:0] KICK_KEY0 = 32'h83E7_0B13,
  parameter logic [31:0] KICK_KEY1 = 32'h95A4_F1E0,
  parameter logic [31:0] LOCK_KEY  = 32'h0F0A_0B00,
  parameter logic [31:0] PRIV_RST  = 32'hAAAA_AAAA,
  localparam int unsigned NDEV     = N_WIDE + 1 + N_STICKY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NDEV-1:0]   dev_en,
  output logic              blocked_err
);

  // Address decode
  logic hit_k0, hit_k1, hit_priv, hit_lock, hit_ctl, hit_stky, hit_once, hit_prot;
  assign hit_k0   = (bus_addr == OFF_KICK0[ADDR_W-1:0]);
  assign hit_k1   = (bus_addr == OFF_KICK1[ADDR_W-1:0]);
  assign hit_priv = (bus_addr == OFF_PRIV[ADDR_W-1:0]);
  assign hit_lock = (bus_addr == OFF_LOCK[ADDR_W-1:0]);
  assign hit_ctl  = (bus_addr == OFF_CTL[ADDR_W-1:0]);
  assign hit_stky = (bus_addr == OFF_STKY[ADDR_W-1:0]);
  assign hit_once = (bus_addr == OFF_ONCE[ADDR_W-1:0]);
  assign hit_prot = hit_priv | hit_lock | hit_ctl | hit_stky | hit_once;

  // Unlock sequencer
  logic kick_open;
  kick_seq #(
    .DATA_W    (DATA_W),
    .KEY_FIRST (KICK_KEY0),
    .KEY_SECOND(KICK_KEY1)
  ) i_kick (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_first (bus_we & hit_k0),
    .wr_second(bus_we & hit_k1),
    .wdata    (bus_wdata),
    .open_o   (kick_open)
  );

  // Stored words
  logic [DATA_W-1:0] lock_q, priv_q;
  logic [ONCE_W-1:0] once_q;
  logic              once_done;
  logic              lock_ok;
  assign lock_ok = (lock_q == LOCK_KEY[DATA_W-1:0]);

  // Write grants, one per protected word
  logic lock_we, ctl_we, stky_we, priv_we, once_we, wr_refused;
  assign lock_we    = bus_we & hit_lock & kick_open;
  assign ctl_we     = bus_we & hit_ctl  & kick_open & lock_ok;
  assign stky_we    = bus_we & hit_stky & kick_open;
  assign priv_we    = bus_we & hit_priv & kick_open;
  assign once_we    = bus_we & hit_once & kick_open & !once_done;
  assign wr_refused = bus_we & hit_prot & !(lock_we | ctl_we | stky_we | priv_we | once_we);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      priv_q <= PRIV_RST[DATA_W-1:0];
    end else begin
      if (lock_we) lock_q <= bus_wdata;
      if (priv_we) priv_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      once_q    <= '0;
      once_done <= 1'b0;
    end else if (once_we) begin
      once_q    <= bus_wdata[ONCE_W-1:0];
      once_done <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          blocked_err <= 1'b0;
    else if (wr_refused) blocked_err <= 1'b1;
  end

  // Device enable bank
  logic [DATA_W-1:0]   ctl_q;
  logic [N_STICKY-1:0] stky_q;
  dev_ctl_bank #(
    .DATA_W  (DATA_W),
    .N_WIDE  (N_WIDE),
    .N_STICKY(N_STICKY)
  ) i_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (ctl_we),
    .sticky_we(stky_we),
    .wdata    (bus_wdata),
    .ctl_q    (ctl_q),
    .sticky_q (stky_q),
    .dev_en   (dev_en)
  );

  // Read mux: keys never come back out
  always_comb begin
    bus_rdata = '0;
    if (hit_priv)      bus_rdata = priv_q;
    else if (hit_ctl)  bus_rdata = ctl_q;
    else if (hit_stky) bus_rdata = {{(DATA_W-N_STICKY){1'b0}}, stky_q};
    else if (hit_once) bus_rdata = {{(DATA_W-ONCE_W){1'b0}}, once_q};
  end

  // R8: the privilege word moves only while the bank was open
  assert_priv_needs_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_q != $past(priv_q)) |-> $past(kick_open));

  // R9: the write-once field is frozen after its first write
  assert_once_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    once_done |=> $stable(once_q));

  // R10: the refusal flag is sticky
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_err |=> blocked_err);

  // R5: key registers read zero
  assert_keys_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_k0 | hit_k1 | hit_lock) |-> (bus_rdata == '0));

endmodule

// File: tb/test_cfg_keyed_regs.sv
module test_cfg_keyed_regs;

  localparam logic [18:0] A_K0   = 19'h00038;
  localparam logic [18:0] A_K1   = 19'h0003C;
  localparam logic [18:0] A_PRIV = 19'h0041C;
  localparam logic [18:0] A_LOCK = 19'h40004;
  localparam logic [18:0] A_CTL  = 19'h40008;
  localparam logic [18:0] A_STKY = 19'h4002C;
  localparam logic [18:0] A_ONCE = 19'h40030;
  localparam logic [31:0] K0 = 32'h83E70B13;
  localparam logic [31:0] K1 = 32'h95A4F1E0;
  localparam logic [31:0] LK = 32'h0F0A0B00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [14:0] dev_en;
  logic        blocked_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  cfg_keyed_regs i_cfg_keyed_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_en(dev_en),
    .blocked_err(blocked_err)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [18:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  // Enables restated from the field rules
  function automatic logic [14:0] want_en(logic [31:0] c, logic [1:0] s);
    logic [14:0] e;
    e = '0;
    for (int i = 0; i < 12; i++) e[i] = (((c >> (2 * i)) & 32'h3) == 32'h1);
    e[12] = ((c >> 30) == 32'h3);
    e[13] = s[0];
    e[14] = s[1];
    return e;
  endfunction

  task automatic unlock();
    wr(A_K0, K0);
    wr(A_K1, K1);
  endtask

  task automatic t_reset();
    rd_chk("R1 ctl",    A_CTL,  32'h0);
    rd_chk("R1 sticky", A_STKY, 32'h0);
    rd_chk("R1 once",   A_ONCE, 32'h0);
    rd_chk("R1 priv",   A_PRIV, 32'hAAAAAAAA);
    chk("R1 dev_en", 32'(dev_en), 32'h0);
    chk("R1 err", 32'(blocked_err), 32'h0);
  endtask

  task automatic t_locked_discard();
    wr(A_PRIV, 32'h12345678);
    rd_chk("R2 locked priv write dropped", A_PRIV, 32'hAAAAAAAA);
    chk("R10 err after refused write", 32'(blocked_err), 32'h1);
  endtask

  task automatic t_order();
    wr(A_K1, K1);
    wr(A_K0, K0);
    wr(A_PRIV, 32'h1);
    rd_chk("R3 half-open rejects write", A_PRIV, 32'hAAAAAAAA);
    wr(A_K0, K0);
    wr(A_K1, 32'hDEADBEEF);
    wr(A_K1, K1);
    wr(A_PRIV, 32'h2);
    rd_chk("R3 wrong second key relocks", A_PRIV, 32'hAAAAAAAA);
    unlock();
    wr(A_PRIV, 32'h12345678);
    rd_chk("R2 R8 open priv write", A_PRIV, 32'h12345678);
  endtask

  task automatic t_keys_hidden();
    rd_chk("R5 kick0 reads 0", A_K0, 32'h0);
    rd_chk("R5 kick1 reads 0", A_K1, 32'h0);
    wr(A_LOCK, 32'h1);
    rd_chk("R5 lock reads 0", A_LOCK, 32'h0);
  endtask

  task automatic t_lock_ctl();
    logic [31:0] w;
    wr(A_CTL, 32'h5);
    rd_chk("R4 ctl refused without lock key", A_CTL, 32'h0);
    wr(A_LOCK, LK);
    w = 32'hC0000079;
    wr(A_CTL, w);
    rd_chk("R4 ctl accepted with lock key", A_CTL, w);
    chk("R6 dev_en pattern A", 32'(dev_en), 32'(want_en(w, 2'b00)));
    w = 32'h40000555;
    wr(A_CTL, w);
    rd_chk("R4 ctl pattern B", A_CTL, w);
    chk("R6 dev_en pattern B", 32'(dev_en), 32'(want_en(w, 2'b00)));
    w = 32'hFFFFFFFF;
    wr(A_CTL, w);
    chk("R6 all-ones enables nothing but top", 32'(dev_en), 32'(want_en(w, 2'b00)));
    w = 32'h00555555;
    wr(A_CTL, w);
    chk("R6 all wide fields enabled", 32'(dev_en), 32'(want_en(w, 2'b00)));
  endtask

  task automatic t_sticky();
    wr(A_STKY, 32'h1);
    rd_chk("R7 set bit0", A_STKY, 32'h1);
    chk("R7 dev13 on", 32'(dev_en[14:13]), 32'h1);
    wr(A_STKY, 32'h2);
    rd_chk("R7 clear refused, set taken", A_STKY, 32'h3);
    chk("R7 dev13 dev14 on", 32'(dev_en[14:13]), 32'h3);
    wr(A_STKY, 32'hFFFFFFF0);
    rd_chk("R7 upper bits read 0", A_STKY, 32'h3);
  endtask

  task automatic t_once();
    wr(A_ONCE, 32'h5A);
    rd_chk("R9 first write stored", A_ONCE, 32'h5A);
    wr(A_ONCE, 32'hA5);
    rd_chk("R9 second write ignored", A_ONCE, 32'h5A);
    chk("R10 err still set", 32'(blocked_err), 32'h1);
  endtask

  task automatic t_relock();
    wr(A_K0, 32'h0);
    wr(A_PRIV, 32'h0);
    rd_chk("R3 relock after bad kick0", A_PRIV, 32'h12345678);
    rd_chk("R11 ctl readable while locked", A_CTL, 32'h00555555);
    rd_chk("R11 unmapped reads 0", 19'h00100, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked_discard();
    t_order();
    t_keys_hidden();
    t_lock_ctl();
    t_sticky();
    t_once();
    t_relock();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule